// File: doc/BRIEF.md
# Serial Management Slave Port

This block is the PHY-side end of a two-wire management link. A station drives a clock (MDC) and a shared data line (MDIO). Every bit is taken on the rising clock edge. Frames are decoded against a strapped 5-bit device address. A frame addressed to this device reaches a 32 x 16-bit register file through a plain read and write port. The register file sits outside the block and is read combinationally. For reads, the block drives the shared line through a separate output-enable pin, so that an external pull-up or another device can own the line the rest of the time.

The port starts out of step with the station. It stays silent until it has seen an unbroken run of at least 32 ones on the line. A malformed start pattern, an unknown opcode or a bad write turnaround throws it back into that state. Once in step, it follows every frame on the wire, including frames for other addresses. It accepts frames packed against each other or separated by any number of idle ones.

Top module: `mdio_slave`

## Requirements
- R1: After reset no frame is acted on (no strobe, no drive) until at least 32 consecutive ones have been sampled. A run of 31 ones followed by a frame leaves every output quiet.
- R2: A frame is, in sampling order: two start bits 0 then 1, a 2-bit opcode, a 5-bit device address, a 5-bit register address, two turnaround bits and 16 data bits. Every field is sent most significant bit first.
- R3: A write (opcode bits 0,1) to the strapped address with turnaround 1,0 raises `reg_wr_en` for exactly the one cycle after the 16th data bit is sampled. In that cycle `reg_addr` and `reg_wr_data` carry the frame's register address and data.
- R4: For a read (opcode bits 1,0) to the strapped address, `reg_rd_en` is high in the cycle after the last register-address bit is sampled, with `mdio_oe` still low. In the next cycle `mdio_oe` rises with `mdio_o` = 0. The 16 words bits then follow MSB first, one per cycle, and `mdio_oe` falls after 17 driven cycles.
- R5: A frame whose device address differs from the strap produces no strobe and never asserts `mdio_oe`.
- R6: A 0 in the second start position, an opcode of 00 or 11, or a write turnaround other than 1,0 (for any address) drops synchronisation. Valid frames are then ignored until a fresh run of 32 ones.
- R7: Once synchronised, a start bit may directly follow the last data bit of the previous frame.
- R8: Idle ones between frames do not affect synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_strap | input | 5 | Device address this port answers to |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Level driven onto the line when enabled |
| mdio_oe | output | 1 | High while the block drives the line |
| reg_rd_en | output | 1 | One-cycle register fetch request |
| reg_addr | output | 5 | Register index for fetch and write |
| reg_rd_data | input | 16 | Combinational read data from the register file |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 16 | Word to be written |

## Verification
All outputs are registered. The fetch request appears one cycle after the final register-address bit is taken. The turnaround zero appears two cycles after it, and data bit 15-k is on the line k+3 cycles after it. The write strobe appears one cycle after the 16th data bit. The bench changes the line on falling edges. It reads the driven read bits at falling edges, within the cycle each bit belongs to. It reads the write strobe 1 ns after the rising edge that takes the last data bit, before anything else changes. Fetch and drive counts are gathered at falling edges and compared once the frame's final edge has passed.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [2:0] {
    S_HUNT, S_IDLE, S_START, S_OP, S_PHY, S_REG, S_TA, S_DATA
  } mgmt_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  // only the two defined opcodes are legal
  function automatic logic opc_known(input logic [1:0] opc);
    return (opc == OPC_READ) || (opc == OPC_WRITE);
  endfunction

  // write turnaround: first bit must be 1, second must be 0
  function automatic logic ta_bit_ok(input logic second, input logic b);
    return second ? !b : b;
  endfunction

  function automatic logic addr_hit(input logic [4:0] got, input logic [4:0] mine);
    return got == mine;
  endfunction
endpackage

// File: rtl/mdio_sync_detect.sv
`timescale 1ns/1ps
module mdio_sync_detect #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunting,
  input  logic bit_in,
  output logic pre_seen
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(PRE_LEN);

  logic [CW-1:0] run_q;

  // counts consecutive ones while out of step; saturates at the target
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!hunting || !bit_in) run_q <= '0;
    else if (run_q != FULL) run_q <= run_q + 1'b1;
  end

  assign pre_seen = (run_q == FULL);
endmodule

// File: rtl/mdio_frame_parser.sv
`timescale 1ns/1ps
module mdio_frame_parser
  import mdio_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          pre_seen,
  input  logic [AW-1:0] my_addr,
  output mgmt_state_e   state_q,
  output logic [1:0]    op_q,
  output logic          match_q,
  output logic [AW-1:0] reg_addr_q,
  output logic          ev_err,
  output logic          ev_rd_fetch,
  output logic          ev_tx_load,
  output logic          ev_wr_commit,
  output logic          ev_frame_end,
  output logic [DW-1:0] wr_word
);
  localparam int MAXF = (DW > AW) ? DW : AW;
  localparam int CW = $clog2(MAXF);
  localparam logic [CW-1:0] ALAST = CW'(AW - 1);
  localparam logic [CW-1:0] DLAST = CW'(DW - 1);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  mgmt_state_e   state_d;
  logic [AW-2:0] phy_sh, reg_sh;
  logic [DW-2:0] dat_sh;
  logic [AW-1:0] phy_full, reg_full;
  logic [1:0]    op_full;
  logic          addr_done, data_done, is_rd, is_wr;
  logic          start_bad, op_bad, ta_bad;

  assign phy_full  = {phy_sh, bit_in};
  assign reg_full  = {reg_sh, bit_in};
  assign wr_word   = {dat_sh, bit_in};
  assign op_full   = {op_q[0], bit_in};
  assign addr_done = (cnt_q == ALAST);
  assign data_done = (cnt_q == DLAST);
  assign is_rd     = (op_q == OPC_READ);
  assign is_wr     = (op_q == OPC_WRITE);

  // protocol faults
  assign start_bad = (state_q == S_START) && !bit_in;
  assign op_bad    = (state_q == S_OP) && (cnt_q == ONE) && !opc_known(op_full);
  assign ta_bad    = (state_q == S_TA) && is_wr && !ta_bit_ok(cnt_q[0], bit_in);
  assign ev_err    = start_bad || op_bad || ta_bad;

  // frame events
  assign ev_rd_fetch  = (state_q == S_REG) && addr_done && is_rd && match_q;
  assign ev_tx_load   = (state_q == S_TA) && (cnt_q == '0) && is_rd && match_q;
  assign ev_frame_end = (state_q == S_DATA) && data_done;
  assign ev_wr_commit = ev_frame_end && is_wr && match_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    case (state_q)
      S_HUNT: begin
        cnt_d = '0;
        if (pre_seen && !bit_in) state_d = S_START;
      end
      S_IDLE: begin
        cnt_d = '0;
        if (!bit_in) state_d = S_START;
      end
      S_START: begin
        cnt_d   = '0;
        state_d = bit_in ? S_OP : S_HUNT;
      end
      S_OP: begin
        if (cnt_q == ONE) begin
          cnt_d   = '0;
          state_d = op_bad ? S_HUNT : S_PHY;
        end
      end
      S_PHY: begin
        if (addr_done) begin
          cnt_d   = '0;
          state_d = S_REG;
        end
      end
      S_REG: begin
        if (addr_done) begin
          cnt_d   = '0;
          state_d = S_TA;
        end
      end
      S_TA: begin
        if (ta_bad) begin
          cnt_d   = '0;
          state_d = S_HUNT;
        end else if (cnt_q == ONE) begin
          cnt_d   = '0;
          state_d = S_DATA;
        end
      end
      S_DATA: begin
        if (data_done) begin
          cnt_d   = '0;
          state_d = S_IDLE;
        end
      end
      default: begin
        cnt_d   = '0;
        state_d = S_HUNT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // field capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= '0;
      match_q    <= 1'b0;
      phy_sh     <= '0;
      reg_sh     <= '0;
      dat_sh     <= '0;
      reg_addr_q <= '0;
    end else begin
      if (state_q == S_START) match_q <= 1'b0;
      if (state_q == S_OP) op_q <= op_full;
      if (state_q == S_PHY) begin
        phy_sh <= phy_full[AW-2:0];
        if (addr_done) match_q <= (phy_full == my_addr);
      end
      if (state_q == S_REG) begin
        reg_sh <= reg_full[AW-2:0];
        if (addr_done) reg_addr_q <= reg_full;
      end
      if (state_q == S_DATA) dat_sh <= wr_word[DW-2:0];
    end
  end
endmodule

// File: rtl/mdio_tx_shift.sv
`timescale 1ns/1ps
module mdio_tx_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          stop,
  input  logic          abort,
  input  logic [DW-1:0] din,
  output logic          mdo,
  output logic          mdoe
);
  logic [DW-1:0] sh_q;

  // load: drive the turnaround zero; afterwards one bit per clock, MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      mdo  <= 1'b0;
      mdoe <= 1'b0;
    end else if (abort) begin
      mdo  <= 1'b0;
      mdoe <= 1'b0;
    end else if (load) begin
      sh_q <= din;
      mdo  <= 1'b0;
      mdoe <= 1'b1;
    end else if (mdoe && stop) begin
      mdo  <= 1'b0;
      mdoe <= 1'b0;
    end else if (mdoe) begin
      mdo  <= sh_q[DW-1];
      sh_q <= {sh_q[DW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mdio_slave.sv
`timescale 1ns/1ps
module mdio_slave
  import mdio_pkg::*;
#(
  parameter int PHY_AW  = 5,
  parameter int REG_DW  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [PHY_AW-1:0] phy_strap,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              reg_rd_en,
  output logic [PHY_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_rd_data,
  output logic              reg_wr_en,
  output logic [REG_DW-1:0] reg_wr_data
);
  mgmt_state_e       fsm_state;
  logic [1:0]        frame_op;
  logic              frame_hit;
  logic              pre_seen;
  logic              ev_err, ev_rd_fetch, ev_tx_load, ev_wr_commit, ev_frame_end;
  logic [REG_DW-1:0] wr_word;
  logic [PHY_AW-1:0] reg_addr_q;

  mdio_sync_detect #(.PRE_LEN(PRE_LEN)) u_sync (
    .clk      (mdc),
    .rst_n    (rst_n),
    .hunting  (fsm_state == S_HUNT),
    .bit_in   (mdio_i),
    .pre_seen (pre_seen)
  );

  mdio_frame_parser #(.AW(PHY_AW), .DW(REG_DW)) u_parse (
    .clk          (mdc),
    .rst_n        (rst_n),
    .bit_in       (mdio_i),
    .pre_seen     (pre_seen),
    .my_addr      (phy_strap),
    .state_q      (fsm_state),
    .op_q         (frame_op),
    .match_q      (frame_hit),
    .reg_addr_q   (reg_addr_q),
    .ev_err       (ev_err),
    .ev_rd_fetch  (ev_rd_fetch),
    .ev_tx_load   (ev_tx_load),
    .ev_wr_commit (ev_wr_commit),
    .ev_frame_end (ev_frame_end),
    .wr_word      (wr_word)
  );

  mdio_tx_shift #(.DW(REG_DW)) u_tx (
    .clk   (mdc),
    .rst_n (rst_n),
    .load  (ev_tx_load),
    .stop  (ev_frame_end),
    .abort (ev_err),
    .din   (reg_rd_data),
    .mdo   (mdio_o),
    .mdoe  (mdio_oe)
  );

  // registered strobes toward the register file
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      reg_rd_en   <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
    end else begin
      reg_rd_en <= ev_rd_fetch;
      reg_wr_en <= ev_wr_commit;
      if (ev_wr_commit) reg_wr_data <= wr_word;
    end
  end

  assign reg_addr = reg_addr_q;
endmodule

// File: rtl/mdio_slave_chk.sv
`timescale 1ns/1ps
module mdio_slave_chk
  import mdio_pkg::*;
#(
  parameter int DW = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_i,
  input mgmt_state_e state,
  input logic [1:0]  op,
  input logic        match,
  input logic        ev_err,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        reg_rd_en,
  input logic        reg_wr_en
);
  localparam int RW = $clog2(DW + 2) + 1;
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};
  logic [RW-1:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_run <= '0;
    else if (!mdio_oe) oe_run <= '0;
    else if (oe_run != RMAX) oe_run <= oe_run + 1'b1;
  end

  p_hunt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_HUNT |-> !reg_wr_en && !reg_rd_en && !mdio_oe);

  p_wr_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(state) == S_DATA && op == OPC_WRITE && match);

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  p_fetch_then_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> mdio_oe && !mdio_o);

  p_fetch_before_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> !mdio_oe);

  p_oe_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> oe_run <= RW'(DW));

  p_drive_only_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> op == OPC_READ && match);

  p_err_resync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> state == S_HUNT);

  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && mdio_i |=> state == S_IDLE);
endmodule

bind mdio_slave mdio_slave_chk #(.DW(REG_DW)) u_chk (
  .clk       (mdc),
  .rst_n     (rst_n),
  .mdio_i    (mdio_i),
  .state     (fsm_state),
  .op        (frame_op),
  .match     (frame_hit),
  .ev_err    (ev_err),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .reg_rd_en (reg_rd_en),
  .reg_wr_en (reg_wr_en)
);

// File: tb/sim_mdio_slave.sv
`timescale 1ns/1ps
module sim_mdio_slave;
  localparam logic [4:0] MY_PHY = 5'h0B;
  localparam int NV = 11;
  // {opcode, device address, register, data, idle ones before frame}
  localparam logic [31:0] VEC [NV] = '{
    {2'b01, 5'h0B, 5'h03, 16'h1234, 4'd0},
    {2'b10, 5'h0B, 5'h03, 16'h0000, 4'd0},
    {2'b01, 5'h0B, 5'h1F, 16'h8001, 4'd0},
    {2'b10, 5'h0B, 5'h1F, 16'h0000, 4'd2},
    {2'b01, 5'h0A, 5'h05, 16'hDEAD, 4'd1},
    {2'b10, 5'h0B, 5'h05, 16'h0000, 4'd0},
    {2'b10, 5'h0C, 5'h05, 16'h0000, 4'd3},
    {2'b01, 5'h0B, 5'h00, 16'h0000, 4'd0},
    {2'b10, 5'h0B, 5'h00, 16'h0000, 4'd0},
    {2'b01, 5'h0B, 5'h10, 16'hFFFF, 4'd5},
    {2'b10, 5'h0B, 5'h10, 16'h0000, 4'd0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_en, m_drv;
  logic mdio_line, mdio_o, mdio_oe, rd_en, wr_en;
  logic [4:0] raddr;
  logic [15:0] rdata, wdata;
  logic [15:0] mem [32];
  logic [15:0] exp_mem [32];
  int n_chk = 0, n_err = 0, rd_cnt = 0, oe_cyc = 0;

  assign mdio_line = mdio_oe ? mdio_o : (m_en ? m_drv : 1'b1);

  mdio_slave u0 (
    .mdc (clk), .rst_n (rst_n), .phy_strap (MY_PHY), .mdio_i (mdio_line),
    .mdio_o (mdio_o), .mdio_oe (mdio_oe), .reg_rd_en (rd_en), .reg_addr (raddr),
    .reg_rd_data (rdata), .reg_wr_en (wr_en), .reg_wr_data (wdata)
  );

  function automatic logic [15:0] seed(input int i);
    return 16'h5A00 ^ (16'(i) * 16'h0111);
  endfunction

  // register file model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= seed(i);
    end else if (wr_en) mem[raddr] <= wdata;
  end
  assign rdata = mem[raddr];

  always @(negedge clk) begin
    if (rd_en) rd_cnt++;
    if (mdio_oe) oe_cyc++;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk);
    m_en = 1'b1;
    m_drv = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  // one frame; returns after the rising edge that takes its last bit (+1 ns)
  task automatic xfer(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                      input logic [4:0] rg, input logic [1:0] ta, input logic [15:0] wd,
                      output logic [15:0] rd, output logic ta1_oe, output logic ta2_oe,
                      output logic ta2_o, output logic rd_seen);
    rd = '0; ta1_oe = 0; ta2_oe = 0; ta2_o = 1; rd_seen = 0;
    drive_bit(st[1]); drive_bit(st[0]);
    drive_bit(op[1]); drive_bit(op[0]);
    for (int i = 4; i >= 0; i--) drive_bit(phy[i]);
    for (int i = 4; i >= 0; i--) drive_bit(rg[i]);
    if (op == 2'b10) begin
      @(negedge clk);
      ta1_oe = mdio_oe; rd_seen = rd_en; m_en = 1'b0;
      @(negedge clk);
      ta2_oe = mdio_oe; ta2_o = mdio_o;
      for (int i = 15; i >= 0; i--) begin
        @(negedge clk);
        rd[i] = mdio_o;
      end
    end else begin
      drive_bit(ta[1]); drive_bit(ta[0]);
      for (int i = 15; i >= 0; i--) drive_bit(wd[i]);
    end
    @(posedge clk);
    #1;
  endtask

  logic [15:0] rd;
  logic t1, t2, t2o, rs;
  int o0, r0;

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) exp_mem[i] = seed(i);
    rst_n = 1'b0; m_en = 1'b1; m_drv = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!mdio_oe && !wr_en && !rd_en, "R1 reset", {mdio_oe, wr_en, rd_en}, 0);
    rst_n = 1'b1;

    // R1: 31 ones is not enough
    drive_bit(0); drive_bit(0); drive_bit(0);
    idle(31);
    xfer(2'b01, 2'b01, MY_PHY, 5'h02, 2'b10, 16'h0F0F, rd, t1, t2, t2o, rs);
    chk(!wr_en, "R1 write before preamble", wr_en, 0);
    drive_bit(0);
    idle(31);
    o0 = oe_cyc; r0 = rd_cnt;
    xfer(2'b01, 2'b10, MY_PHY, 5'h02, 2'b00, 16'h0, rd, t1, t2, t2o, rs);
    chk(oe_cyc == o0 && rd_cnt == r0, "R1 read before preamble", oe_cyc - o0, 0);
    drive_bit(0);
    idle(32);
    xfer(2'b01, 2'b01, MY_PHY, 5'h02, 2'b10, 16'h0F0F, rd, t1, t2, t2o, rs);
    chk(wr_en && raddr == 5'h02 && wdata == 16'h0F0F, "R1 write after preamble", {wr_en, raddr, wdata}, {1'b1, 5'h02, 16'h0F0F});
    exp_mem[2] = 16'h0F0F;

    // table: R2 R3 R4 R5 R7 R8
    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      v = VEC[k];
      idle(int'(v[3:0]));
      o0 = oe_cyc; r0 = rd_cnt;
      xfer(2'b01, v[31:30], v[29:25], v[24:20], 2'b10, v[19:4], rd, t1, t2, t2o, rs);
      if (v[31:30] == 2'b01) begin
        if (v[29:25] == MY_PHY) begin
          chk(wr_en && raddr == v[24:20] && wdata == v[19:4], "R3/R7 write strobe",
              {wr_en, raddr, wdata}, {1'b1, v[24:20], v[19:4]});
          exp_mem[v[24:20]] = v[19:4];
        end else
          chk(!wr_en, "R5 foreign write", wr_en, 0);
      end else begin
        if (v[29:25] == MY_PHY) begin
          chk(rd == exp_mem[v[24:20]], "R2/R4 read data", rd, exp_mem[v[24:20]]);
          chk(!t1 && rs && t2 && !t2o, "R4 turnaround", {t1, rs, t2, t2o}, 4'b0110);
          chk(oe_cyc - o0 == 17 && rd_cnt - r0 == 1, "R4 drive length", oe_cyc - o0, 17);
        end else
          chk(oe_cyc == o0 && rd_cnt == r0, "R5 foreign read", oe_cyc - o0, 0);
      end
    end

    // R6: bad opcode, then a valid frame is ignored
    xfer(2'b01, 2'b11, MY_PHY, 5'h04, 2'b10, 16'h2222, rd, t1, t2, t2o, rs);
    chk(!wr_en, "R6 opcode 11", wr_en, 0);
    xfer(2'b01, 2'b01, MY_PHY, 5'h04, 2'b10, 16'h1357, rd, t1, t2, t2o, rs);
    chk(!wr_en, "R6 ignored after bad opcode", wr_en, 0);
    idle(32);
    xfer(2'b01, 2'b01, MY_PHY, 5'h04, 2'b10, 16'h1357, rd, t1, t2, t2o, rs);
    chk(wr_en && wdata == 16'h1357, "R6 resync", {wr_en, wdata}, {1'b1, 16'h1357});
    exp_mem[4] = 16'h1357;

    // R6: bad start, following read ignored
    xfer(2'b00, 2'b01, MY_PHY, 5'h04, 2'b10, 16'h2424, rd, t1, t2, t2o, rs);
    chk(!wr_en, "R6 start 00", wr_en, 0);
    o0 = oe_cyc;
    xfer(2'b01, 2'b10, MY_PHY, 5'h04, 2'b00, 16'h0, rd, t1, t2, t2o, rs);
    chk(oe_cyc == o0, "R6 read ignored after bad start", oe_cyc - o0, 0);
    drive_bit(0);
    idle(32);

    // R6: bad write turnaround, register untouched
    xfer(2'b01, 2'b01, MY_PHY, 5'h06, 2'b11, 16'h4444, rd, t1, t2, t2o, rs);
    chk(!wr_en, "R6 turnaround 11", wr_en, 0);
    idle(32);
    xfer(2'b01, 2'b10, MY_PHY, 5'h06, 2'b00, 16'h0, rd, t1, t2, t2o, rs);
    chk(rd == exp_mem[6], "R6 register kept", rd, exp_mem[6]);

    // R6: bad turnaround on a foreign frame also drops sync
    xfer(2'b01, 2'b01, 5'h0A, 5'h06, 2'b00, 16'h4242, rd, t1, t2, t2o, rs);
    xfer(2'b01, 2'b01, MY_PHY, 5'h06, 2'b10, 16'h6666, rd, t1, t2, t2o, rs);
    chk(!wr_en, "R6 foreign fault", wr_en, 0);
    idle(40);
    xfer(2'b01, 2'b10, MY_PHY, 5'h06, 2'b00, 16'h0, rd, t1, t2, t2o, rs);
    chk(rd == exp_mem[6], "R6 foreign fault register kept", rd, exp_mem[6]);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule